// File: doc/BRIEF.md
# Queue Status Interrupt Controller

This block turns per-queue status flags from 64 hardware queues into two interrupt lines. The queues form two halves of 32. The lower half (queues 0 to 31) sends a 4-bit status nibble per queue. Each lower queue has a programmable 3-bit source code. The code picks one flag from the nibble and can invert it. The upper half (queues 32 to 63) sends one "not nearly empty" flag per queue, and that flag is always its interrupt cause.

Status inputs are registered first. When a queue's condition is true, the block sets a sticky pending bit. Software clears pending bits by writing ones. An interrupt line is high while its half has any bit that is both pending and enabled. Each half also has a read-only register that gives the highest-numbered queue that is pending and enabled. Software uses it to pick the next queue to service.

All state is reached through a 32-bit word-addressed port. A write takes effect on the clock edge where `reg_we_i` is high. Reads are combinational from `reg_addr_i`.

Top module: `qstat_irq_ctrl`

## Requirements
- R1: While reset is asserted and right after it: source registers (addresses 0-3), enables (4, 5) and pending bits (6, 7) read zero, and both interrupt outputs are low. The lower status mirror (addresses 10-13) reads 0x33333333 and the upper mirror (14) reads zero.
- R2: Lower queue q has its source code in register q/8 (address q/8), bits (q mod 8)*4+2 down to (q mod 8)*4. Code bits 1:0 select a status flag: 0 empty, 1 nearly empty, 2 nearly full, 3 full. These are status nibble bits 0 to 3, and queue q's nibble is `lo_stat_i[4q+3:4q]`. Code bit 2 set inverts the selected flag.
- R3: Bit 3 of every source nibble is reserved. It reads zero, and writing one to it has no effect.
- R4: An upper queue 32+i uses `hi_ne_i[i]` as its condition. This is fixed; the source registers have no effect on it.
- R5: A status input is registered at the first clock edge. The matching pending bit is set at the second edge when the condition is true, and it stays set after the condition goes false.
- R6: Writing to address 6 (lower) or 7 (upper) clears every pending bit where the written data is 1. Bits where the data is 0 are left unchanged. If the condition is still true in the clearing cycle, the bit stays set.
- R7: `irq_lo_o` / `irq_hi_o` is high exactly when the AND of that half's pending and enable (addresses 4 / 5) bits is non-zero. A disabled pending bit is kept but raises no interrupt.
- R8: Address 8 (lower) and address 9 (upper) read bit 31 = valid and bits 5:0 = the absolute number of the highest queue that is both pending and enabled. The register reads all zero when there is none.
- R9: Addresses 10-13 read the registered lower status, 32 bits of `lo_stat_i` each, lowest word first. Address 14 reads the registered `hi_ne_i`.
- R10: Writes to read-only addresses (8-15) change no state. Address 15 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lo_stat_i | input | 128 | Status nibble per lower queue: empty, nearly empty, nearly full, full |
| hi_ne_i | input | 32 | Not-nearly-empty flag per upper queue |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_lo_o | output | 1 | Interrupt for queues 0-31 |
| irq_hi_o | output | 1 | Interrupt for queues 32-63 |

## Verification
The bench runs all eight source codes against two complementary nibbles on one queue. A design that wires the flag select wrongly or drops the invert bit would set the wrong pending bit. It clears a pending bit while its condition is still true. A design where clear wins over set would lose a level that is still active. It checks the pending latency at both one and two cycles, so an extra or missing register stage shows up. It enables bits above and below each other so that a lowest-first encoder, or one that ignores the enable, reports the wrong queue number. It also writes to the read-only addresses and writes ones into the reserved nibble bits, to catch a decoder that aliases them.

// File: rtl/qsic_pkg.sv
package qsic_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned CODE_W = 3;

  typedef enum logic [1:0] {
    FLAG_EMPTY  = 2'd0,
    FLAG_NEMPTY = 2'd1,
    FLAG_NFULL  = 2'd2,
    FLAG_FULL   = 2'd3
  } flag_sel_e;

  typedef struct packed {
    logic      inv;
    flag_sel_e sel;
  } src_code_t;

  localparam logic [3:0] A_SRC0   = 4'd0;
  localparam logic [3:0] A_EN_LO  = 4'd4;
  localparam logic [3:0] A_EN_HI  = 4'd5;
  localparam logic [3:0] A_PND_LO = 4'd6;
  localparam logic [3:0] A_PND_HI = 4'd7;
  localparam logic [3:0] A_TOP_LO = 4'd8;
  localparam logic [3:0] A_TOP_HI = 4'd9;
  localparam logic [3:0] A_STAT0  = 4'd10;
  localparam logic [3:0] A_NE_HI  = 4'd14;
endpackage

// File: rtl/qsic_cond_eval.sv
module qsic_cond_eval
  import qsic_pkg::*;
#(
  parameter int unsigned NQ = 32
) (
  input  logic [NQ*NIB_W-1:0] stat_i,
  input  logic [NQ*NIB_W-1:0] src_i,
  output logic [NQ-1:0]       cond_o
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    src_code_t              code;
    logic [NIB_W-1:0]       nib;
    assign code = src_code_t'(src_i[q*NIB_W +: CODE_W]);
    assign nib  = stat_i[q*NIB_W +: NIB_W];
    assign cond_o[q] = nib[code.sel] ^ code.inv;
  end
endmodule

// File: rtl/qsic_pend_half.sv
module qsic_pend_half #(
  parameter int unsigned NQ    = 32,
  parameter int unsigned IDX_W = $clog2(NQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NQ-1:0]    set_i,
  input  logic [NQ-1:0]    clr_i,
  input  logic             en_we_i,
  input  logic [NQ-1:0]    en_wdata_i,
  output logic [NQ-1:0]    en_o,
  output logic [NQ-1:0]    pend_o,
  output logic             irq_o,
  output logic             top_vld_o,
  output logic [IDX_W-1:0] top_idx_o
);
  logic [NQ-1:0] pend_q, en_q, act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_i) | set_i;  // set wins over clear
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign act    = pend_q & en_q;
  assign irq_o  = |act;
  assign en_o   = en_q;
  assign pend_o = pend_q;

  // highest index wins
  always_comb begin
    top_vld_o = 1'b0;
    top_idx_o = '0;
    for (int i = 0; i < NQ; i++) begin
      if (act[i]) begin
        top_vld_o = 1'b1;
        top_idx_o = IDX_W'(i);
      end
    end
  end

  assert_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(set_i)) == $past(set_i)));
  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));
  assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(clr_i & ~set_i)) == '0));
  assert_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == top_vld_o);
  assert_top_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_vld_o |-> (act[top_idx_o] && (((act >> top_idx_o) >> 1) == '0)));
endmodule

// File: rtl/qstat_irq_ctrl.sv
module qstat_irq_ctrl
  import qsic_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW*NIB_W-1:0] lo_stat_i,
  input  logic [DW-1:0]     hi_ne_i,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  localparam int unsigned NREG  = NIB_W;  // words of nibbles per half
  localparam int unsigned IDX_W = $clog2(DW);
  localparam int unsigned PADW  = DW - 2 - IDX_W;

  function automatic logic [DW-1:0] src_mask();
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = ((i % NIB_W) != NIB_W - 1);
    return m;
  endfunction
  localparam logic [DW-1:0] SRC_MASK = src_mask();

  logic [NREG-1:0][DW-1:0] src_q, stat_q;
  logic [DW-1:0] ne_q;
  logic [DW-1:0] cond_lo, clr_lo, clr_hi;
  logic [DW-1:0] en_lo, en_hi, pnd_lo, pnd_hi;
  logic          top_lo_vld, top_hi_vld;
  logic [IDX_W-1:0] top_lo_idx, top_hi_idx;
  logic [1:0]    stat_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= {(NREG*DW/NIB_W){4'h3}};
      ne_q   <= '0;
    end else begin
      stat_q <= lo_stat_i;
      ne_q   <= hi_ne_i;
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) src_q[r] <= '0;
      else if (reg_we_i && reg_addr_i == A_SRC0 + AW'(r))
        src_q[r] <= reg_wdata_i & SRC_MASK;
    end
    assert_rsvd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_q[r] & ~SRC_MASK) == '0);
  end

  qsic_cond_eval #(.NQ(DW)) u_cond (
    .stat_i (stat_q),
    .src_i  (src_q),
    .cond_o (cond_lo)
  );

  assign clr_lo = (reg_we_i && reg_addr_i == A_PND_LO) ? reg_wdata_i : '0;
  assign clr_hi = (reg_we_i && reg_addr_i == A_PND_HI) ? reg_wdata_i : '0;

  qsic_pend_half #(.NQ(DW), .IDX_W(IDX_W)) u_lo (
    .clk_i, .rst_ni,
    .set_i      (cond_lo),
    .clr_i      (clr_lo),
    .en_we_i    (reg_we_i && reg_addr_i == A_EN_LO),
    .en_wdata_i (reg_wdata_i),
    .en_o       (en_lo),
    .pend_o     (pnd_lo),
    .irq_o      (irq_lo_o),
    .top_vld_o  (top_lo_vld),
    .top_idx_o  (top_lo_idx)
  );

  qsic_pend_half #(.NQ(DW), .IDX_W(IDX_W)) u_hi (
    .clk_i, .rst_ni,
    .set_i      (ne_q),
    .clr_i      (clr_hi),
    .en_we_i    (reg_we_i && reg_addr_i == A_EN_HI),
    .en_wdata_i (reg_wdata_i),
    .en_o       (en_hi),
    .pend_o     (pnd_hi),
    .irq_o      (irq_hi_o),
    .top_vld_o  (top_hi_vld),
    .top_idx_o  (top_hi_idx)
  );

  assign stat_sel = 2'(reg_addr_i - A_STAT0);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      4'd0, 4'd1, 4'd2, 4'd3: reg_rdata_o = src_q[reg_addr_i[1:0]];
      A_EN_LO:  reg_rdata_o = en_lo;
      A_EN_HI:  reg_rdata_o = en_hi;
      A_PND_LO: reg_rdata_o = pnd_lo;
      A_PND_HI: reg_rdata_o = pnd_hi;
      A_TOP_LO: reg_rdata_o = top_lo_vld ? {1'b1, {PADW{1'b0}}, 1'b0, top_lo_idx} : '0;
      A_TOP_HI: reg_rdata_o = top_hi_vld ? {1'b1, {PADW{1'b0}}, 1'b1, top_hi_idx} : '0;
      4'd10, 4'd11, 4'd12, 4'd13: reg_rdata_o = stat_q[stat_sel];
      A_NE_HI:  reg_rdata_o = ne_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assert_fixed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pnd_hi & $past(ne_q)) == $past(ne_q)));
  assert_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_lo == '0) |-> !irq_lo_o);
endmodule

// File: tb/qstat_irq_ctrl_test.sv
module qstat_irq_ctrl_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [127:0] lo_stat_i = '0;
  logic [31:0]  hi_ne_i = '0;
  logic         reg_we_i = 1'b0;
  logic [3:0]   reg_addr_i = '0;
  logic [31:0]  reg_wdata_i = '0;
  logic [31:0]  reg_rdata_o;
  logic         irq_lo_o, irq_hi_o;
  int checks = 0;
  int errors = 0;

  qstat_irq_ctrl uut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic quiesce();
    lo_stat_i = '0; hi_ne_i = '0;
    for (int r = 0; r < 6; r++) wr(4'(r), 32'h0);
    repeat (3) @(negedge clk_i);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd7, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    #2;
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), v); chk("R1 zero after reset", v, 32'h0);
    end
    rd(4'd10, v); chk("R1 lower status reset", v, 32'h3333_3333);
    rd(4'd14, v); chk("R1 upper status reset", v, 32'h0);
    chk("R1 irq low", {30'd0, irq_hi_o, irq_lo_o}, 32'h0);
    @(negedge clk_i) rst_ni = 1'b1;
  endtask

  task automatic t_src_select();
    logic [31:0] v;
    logic [3:0] nib;
    quiesce();
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 2; k++) begin
        nib = k ? 4'hA : 4'h5;
        wr(4'd1, 32'(c) << 4);          // queue 9 = reg 1, bits 6:4
        lo_stat_i = '0;
        lo_stat_i[36 +: 4] = nib;
        repeat (3) @(negedge clk_i);
        wr(4'd6, 32'hFFFF_FFFF);        // R6: still-true condition survives
        rd(4'd6, v);
        chk("R2 R6 select/invert queue 9", v,
            32'(nib[c[1:0]] ^ c[2]) << 9);
      end
    end
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    quiesce();
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v); chk("R3 reserved bits", v, 32'h7777_7777);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_upper();
    logic [31:0] v;
    quiesce();
    wr(4'd0, 32'h7777_7777);            // R4: lower codes must not matter
    hi_ne_i = 32'h0000_0080;
    @(negedge clk_i);
    rd(4'd7, v); chk("R5 no pending after one edge", v, 32'h0);
    @(negedge clk_i);
    rd(4'd7, v); chk("R4 upper pending set", v, 32'h80);
    hi_ne_i = '0;
    repeat (3) @(negedge clk_i);
    rd(4'd7, v); chk("R5 sticky", v, 32'h80);
    wr(4'd7, 32'h0);
    rd(4'd7, v); chk("R6 zero write keeps", v, 32'h80);
    wr(4'd7, 32'h80);
    rd(4'd7, v); chk("R6 one write clears", v, 32'h0);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_irq_top();
    logic [31:0] v;
    quiesce();
    hi_ne_i = 32'h8000_0080;
    repeat (2) @(negedge clk_i);
    hi_ne_i = '0;
    repeat (2) @(negedge clk_i);
    chk("R7 disabled no irq", {31'd0, irq_hi_o}, 32'h0);
    rd(4'd9, v); chk("R8 none enabled", v, 32'h0);
    wr(4'd5, 32'hFFFF_FFFF);
    chk("R7 irq hi on enable", {31'd0, irq_hi_o}, 32'h1);
    rd(4'd9, v); chk("R8 highest upper 63", v, 32'h8000_003F);
    wr(4'd5, 32'h0000_0080);
    rd(4'd9, v); chk("R8 upper 39 when 63 masked", v, 32'h8000_0027);
    chk("R7 lower irq stays low", {31'd0, irq_lo_o}, 32'h0);
    wr(4'd5, 32'h0);
    chk("R7 irq drops", {31'd0, irq_hi_o}, 32'h0);
    rd(4'd7, v); chk("R7 pending kept when disabled", v, 32'h8000_0080);

    lo_stat_i = '0;
    lo_stat_i[12] = 1'b1;                // queue 3 empty
    lo_stat_i[80] = 1'b1;                // queue 20 empty
    repeat (2) @(negedge clk_i);
    lo_stat_i = '0;
    repeat (2) @(negedge clk_i);
    wr(4'd4, 32'h0010_0008);
    chk("R7 irq lo", {31'd0, irq_lo_o}, 32'h1);
    rd(4'd8, v); chk("R8 highest lower 20", v, 32'h8000_0014);
    wr(4'd4, 32'h0000_0008);
    rd(4'd8, v); chk("R8 lower 3", v, 32'h8000_0003);
  endtask

  task automatic t_mirror();
    logic [31:0] v;
    lo_stat_i = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    hi_ne_i = 32'hA5A5_5A5A;
    @(negedge clk_i);
    for (int r = 0; r < 4; r++) begin
      rd(4'(10 + r), v); chk("R9 lower mirror", v, lo_stat_i[r*32 +: 32]);
    end
    rd(4'd14, v); chk("R9 upper mirror", v, 32'hA5A5_5A5A);
    wr(4'd10, 32'h0);
    rd(4'd10, v); chk("R10 mirror write ignored", v, 32'h7654_3210);
    wr(4'd9, 32'hFFFF_FFFF);
    rd(4'd5, v); chk("R10 top write ignored", v, 32'h0);
    wr(4'd15, 32'hFFFF_FFFF);
    rd(4'd15, v); chk("R10 addr 15 zero", v, 32'h0);
    rd(4'd4, v); chk("R10 enable untouched", v, 32'h8);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_src_select();
    t_reserved();
    t_upper();
    t_irq_top();
    t_mirror();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule